// File: doc/BRIEF.md
# Timestamp-Matching Event Builder

This block collects hit packets from many front-end sources and sorts them into events. Each incoming packet carries a 24-bit timestamp, a 16-bit source address and a 64-bit hit pattern. Packets that share a timestamp land in the same event buffer. A buffer becomes ready for the host when a packet with a later timestamp arrives, or when the input has been quiet for a programmable number of cycles. The host reads a ready buffer over a simple register-mapped bus and then hands the buffer back by writing its index to a release register.

The block also keeps saturating packet counters for each source, a late-packet counter and an overflow counter. It carries slow-control accesses from the host to front-end devices over a request/acknowledge port. The answer to each access, or a timeout error if none comes, is held in a register that the host can read.

The host bus is a single-cycle write strobe with a combinational read. Bit 9 of the address selects the packet storage. Below that, offsets 0x00–0x03 hold the buffer status words, 0x08 is the release register, 0x09 the idle limit, 0x0A the late counter, 0x0B the overflow counter, 0x0C the slow-control command, 0x0D the slow-control write data, 0x0E the slow-control response, and 0x10–0x1F the source counters.

Top module: `evt_builder`

## Requirements
- R1: A stored packet is readable at address {1, buffer[1:0], slot[4:0], word[1:0]}. Word 0 is hits[31:0], word 1 is hits[63:32], word 2 is the timestamp zero-extended, and word 3 is the source address zero-extended.
- R2: Packets whose timestamp equals that of the open buffer go into consecutive slots of that buffer. Its status word (offset = buffer index) reads {ready[31], open[30], count[29:24], timestamp[23:0]}.
- R3: A packet with a later timestamp than the open buffer marks that buffer ready. It then opens the lowest-indexed buffer that is neither ready nor open, with this packet in slot 0. A packet arriving while no buffer is open opens one in the same way.
- R4: The open buffer becomes ready once the idle limit (offset 0x09, reset value 100) has elapsed in cycles since its last accepted packet. A limit of 0 disables the timeout.
- R5: A packet older than the open buffer is discarded and increments the late counter (offset 0x0A); the buffer is left unchanged.
- R6: A packet is dropped and the overflow counter (offset 0x0B) increments in two cases: it needs a new buffer and none is free, or it matches a buffer that already holds 32 packets.
- R7: Writing an index to offset 0x08 clears that buffer's status to zero if the buffer is ready; the buffer can then be reused. The write has no effect on a buffer that is not ready.
- R8: Every received packet increments the counter selected by source[3:0] (offset 0x10 + index). Each counter saturates at 255.
- R9: Writing offset 0x0C launches a slow-control access. The write flag is bit 31, the target is bits [23:16], the register index is bits [15:8], and the write data comes from offset 0x0D. The request is held until acknowledged, and the response at offset 0x0E reads {busy[31], error[30], done[29], read data[15:0]}.
- R10: An access that is not acknowledged within 64 cycles ends with the error and done bits set and the request dropped.
- R11: After reset all status words, counters and the slow-control response read zero, and no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | Packet strobe |
| pkt_ts | input | 24 | Packet timestamp |
| pkt_src | input | 16 | Packet source address |
| pkt_hits | input | 64 | Packet hit pattern |
| host_addr | input | 10 | Host register address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| sc_req | output | 1 | Slow-control request |
| sc_we | output | 1 | Slow-control write flag |
| sc_tgt | output | 8 | Slow-control target |
| sc_idx | output | 8 | Slow-control register index |
| sc_wdata | output | 16 | Slow-control write data |
| sc_ack | input | 1 | Slow-control acknowledge |
| sc_rdata | input | 16 | Slow-control read data |

## Verification
A wrong open-buffer index or timestamp shows up in the status words on the very next host read. It appears as a buffer that is ready and open at once, as a count that lands in the wrong buffer, or as the wrong buffer being chosen when a later timestamp arrives. A corrupted slot pointer shows up as mismatched packet words when a stored packet is read back. A faulty idle counter shifts the cycle in which the ready bit appears, and the bench brackets that cycle from both sides. Slow-control faults appear within one access as the wrong request fields, a dropped request, or a response that has the wrong error or done bits.

// File: rtl/eb_pkg.sv
package eb_pkg;
    localparam int TS_W  = 24;
    localparam int SRC_W = 16;
    localparam int HIT_W = 64;
    localparam int HA_W  = 10;
    localparam int HD_W  = 32;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [SRC_W-1:0] src;
        logic [HIT_W-1:0] hits;
    } pkt_t;
endpackage

// File: rtl/eb_src_counters.sv
module eb_src_counters #(
    parameter int NSRC = 16,
    parameter int CW   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit_valid,
    input  logic [$clog2(NSRC)-1:0]      hit_idx,
    output logic [NSRC-1:0][CW-1:0]      counts
);
    localparam logic [CW-1:0] MAXV = '1;

    for (genvar g = 0; g < NSRC; g++) begin : g_cnt
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (hit_valid && hit_idx == ($clog2(NSRC))'(g) && cnt_q != MAXV)
                cnt_d = cnt_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign counts[g] = cnt_q;

        // R8
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q == MAXV |=> cnt_q == MAXV);
    end
endmodule

// File: rtl/eb_slowctl.sv
module eb_slowctl #(
    parameter int TGT_W   = 8,
    parameter int IDX_W   = 8,
    parameter int DW      = 16,
    parameter int TIMEOUT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_we,
    input  logic [TGT_W-1:0] cmd_tgt,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [DW-1:0]    cmd_wdata,
    output logic             sc_req,
    output logic             sc_we,
    output logic [TGT_W-1:0] sc_tgt,
    output logic [IDX_W-1:0] sc_idx,
    output logic [DW-1:0]    sc_wdata,
    input  logic             sc_ack,
    input  logic [DW-1:0]    sc_rdata,
    output logic             rsp_busy,
    output logic             rsp_err,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_data
);
    localparam int TM_W = $clog2(TIMEOUT) + 1;

    typedef struct packed {
        logic             busy;
        logic             err;
        logic             done;
        logic             we;
        logic [TGT_W-1:0] tgt;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic [TM_W-1:0]  timer;
    } sc_st_t;

    sc_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (cmd_valid) begin
                s_d.busy  = 1'b1;
                s_d.err   = 1'b0;
                s_d.done  = 1'b0;
                s_d.we    = cmd_we;
                s_d.tgt   = cmd_tgt;
                s_d.idx   = cmd_idx;
                s_d.wdata = cmd_wdata;
                s_d.rdata = '0;
                s_d.timer = '0;
            end
        end else if (sc_ack) begin
            s_d.busy  = 1'b0;
            s_d.done  = 1'b1;
            s_d.rdata = s_q.we ? '0 : sc_rdata;
        end else if (s_q.timer == TM_W'(TIMEOUT - 1)) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.err  = 1'b1;
        end else begin
            s_d.timer = s_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sc_req   = s_q.busy;
    assign sc_we    = s_q.we;
    assign sc_tgt   = s_q.tgt;
    assign sc_idx   = s_q.idx;
    assign sc_wdata = s_q.wdata;
    assign rsp_busy = s_q.busy;
    assign rsp_err  = s_q.err;
    assign rsp_done = s_q.done;
    assign rsp_data = s_q.rdata;

    // R9
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req && !sc_ack |=> !sc_req || ($stable(sc_tgt) && $stable(sc_idx) && $stable(sc_we)));

    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_err) |-> !sc_req && rsp_done);
endmodule

// File: rtl/eb_grouper.sv
module eb_grouper
    import eb_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int DEPTH = 32,
    parameter int TO_W  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  pkt_t                                 in_pkt,
    input  logic                                 rel_valid,
    input  logic [$clog2(NBUF)-1:0]              rel_idx,
    input  logic [TO_W-1:0]                      idle_limit,
    input  logic [$clog2(NBUF)-1:0]              rd_buf,
    input  logic [$clog2(DEPTH)-1:0]             rd_slot,
    output pkt_t                                 rd_pkt,
    output logic [NBUF-1:0]                      buf_ready,
    output logic [NBUF-1:0]                      buf_open,
    output logic [NBUF-1:0][TS_W-1:0]            buf_ts,
    output logic [NBUF-1:0][$clog2(DEPTH):0]     buf_cnt,
    output logic [15:0]                          late_cnt,
    output logic [15:0]                          ovf_cnt
);
    localparam int BI_W   = $clog2(NBUF);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int MEM_N  = NBUF * DEPTH;

    typedef struct packed {
        logic [NBUF-1:0]             ready;
        logic                        open_v;
        logic [BI_W-1:0]             open_idx;
        logic [NBUF-1:0][TS_W-1:0]   ts;
        logic [NBUF-1:0][CNT_W-1:0]  cnt;
        logic [TO_W-1:0]             idle;
        logic [15:0]                 late;
        logic [15:0]                 ovf;
    } grp_st_t;

    grp_st_t s_d, s_q;
    logic                   wr_en;
    logic [BI_W+SLOT_W-1:0] wr_addr;
    logic                   free_found;
    logic [BI_W-1:0]        free_idx;
    logic [TS_W-1:0]        open_ts;
    pkt_t                   mem [MEM_N];

    always_comb begin
        s_d        = s_q;
        wr_en      = 1'b0;
        wr_addr    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        open_ts    = s_q.ts[s_q.open_idx];

        if (rel_valid && s_q.ready[rel_idx]) begin
            s_d.ready[rel_idx] = 1'b0;
            s_d.cnt[rel_idx]   = '0;
            s_d.ts[rel_idx]    = '0;
        end

        for (int i = NBUF - 1; i >= 0; i--) begin
            if (!s_q.ready[i] && !(s_q.open_v && s_q.open_idx == BI_W'(i))) begin
                free_found = 1'b1;
                free_idx   = BI_W'(i);
            end
        end

        if (in_valid) begin
            if (!s_q.open_v || in_pkt.ts > open_ts) begin
                if (s_q.open_v) begin
                    s_d.ready[s_q.open_idx] = 1'b1;
                    s_d.open_v = 1'b0;
                end
                if (free_found) begin
                    s_d.open_v        = 1'b1;
                    s_d.open_idx      = free_idx;
                    s_d.ts[free_idx]  = in_pkt.ts;
                    s_d.cnt[free_idx] = CNT_W'(1);
                    s_d.idle          = '0;
                    wr_en             = 1'b1;
                    wr_addr           = {free_idx, SLOT_W'(0)};
                end else if (s_q.ovf != '1) begin
                    s_d.ovf = s_q.ovf + 16'd1;
                end
            end else if (in_pkt.ts < open_ts) begin
                if (s_q.late != '1) s_d.late = s_q.late + 16'd1;
            end else if (s_q.cnt[s_q.open_idx] == CNT_W'(DEPTH)) begin
                if (s_q.ovf != '1) s_d.ovf = s_q.ovf + 16'd1;
            end else begin
                wr_en                   = 1'b1;
                wr_addr                 = {s_q.open_idx, s_q.cnt[s_q.open_idx][SLOT_W-1:0]};
                s_d.cnt[s_q.open_idx]   = s_q.cnt[s_q.open_idx] + 1'b1;
                s_d.idle                = '0;
            end
        end else if (s_q.open_v && idle_limit != '0) begin
            if (({1'b0, s_q.idle} + 1'b1) >= {1'b0, idle_limit}) begin
                s_d.ready[s_q.open_idx] = 1'b1;
                s_d.open_v              = 1'b0;
                s_d.idle                = '0;
            end else begin
                s_d.idle = s_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= in_pkt;
    end

    assign rd_pkt = mem[{rd_buf, rd_slot}];

    for (genvar b = 0; b < NBUF; b++) begin : g_stat
        assign buf_open[b] = s_q.open_v && s_q.open_idx == BI_W'(b);
    end

    assign buf_ready = s_q.ready;
    assign buf_ts    = s_q.ts;
    assign buf_cnt   = s_q.cnt;
    assign late_cnt  = s_q.late;
    assign ovf_cnt   = s_q.ovf;

    // R2
    open_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open_v |-> s_q.cnt[s_q.open_idx] != '0 && s_q.cnt[s_q.open_idx] <= CNT_W'(DEPTH));

    // R3
    open_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_open & buf_ready) == '0 && $onehot0(buf_open));

    // R6
    ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf != '1 |=> s_q.ovf >= $past(s_q.ovf));
endmodule

// File: rtl/evt_builder.sv
module evt_builder
    import eb_pkg::*;
#(
    parameter int          NBUF       = 4,
    parameter int          DEPTH      = 32,
    parameter int          NSRC       = 16,
    parameter int          SRC_CW     = 8,
    parameter int          SC_TIMEOUT = 64,
    parameter logic [15:0] IDLE_DEF   = 16'd100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [23:0]      pkt_ts,
    input  logic [15:0]      pkt_src,
    input  logic [63:0]      pkt_hits,
    input  logic [9:0]       host_addr,
    input  logic             host_we,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             sc_req,
    output logic             sc_we,
    output logic [7:0]       sc_tgt,
    output logic [7:0]       sc_idx,
    output logic [15:0]      sc_wdata,
    input  logic             sc_ack,
    input  logic [15:0]      sc_rdata
);
    localparam int BI_W   = $clog2(NBUF);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int SI_W   = $clog2(NSRC);
    localparam logic [5:0] A_REL  = 6'h08;
    localparam logic [5:0] A_IDLE = 6'h09;
    localparam logic [5:0] A_LATE = 6'h0A;
    localparam logic [5:0] A_OVF  = 6'h0B;
    localparam logic [5:0] A_CMD  = 6'h0C;
    localparam logic [5:0] A_WD   = 6'h0D;
    localparam logic [5:0] A_RSP  = 6'h0E;
    localparam int         A_SRC  = 16;

    typedef struct packed {
        logic [15:0] idle_lim;
        logic [15:0] sc_wd;
    } regs_t;

    regs_t r_d, r_q;
    pkt_t  in_pkt, rd_pkt;
    logic [5:0] ra;
    logic       reg_wr;
    logic [NBUF-1:0]               buf_ready, buf_open;
    logic [NBUF-1:0][TS_W-1:0]     buf_ts;
    logic [NBUF-1:0][CNT_W-1:0]    buf_cnt;
    logic [15:0]                   late_cnt, ovf_cnt;
    logic [NSRC-1:0][SRC_CW-1:0]   src_counts;
    logic rsp_busy, rsp_err, rsp_done;
    logic [15:0] rsp_data;

    assign in_pkt = '{ts: pkt_ts, src: pkt_src, hits: pkt_hits};
    assign ra     = host_addr[5:0];
    assign reg_wr = host_we && !host_addr[9];

    always_comb begin
        r_d = r_q;
        if (reg_wr && ra == A_IDLE) r_d.idle_lim = host_wdata[15:0];
        if (reg_wr && ra == A_WD)   r_d.sc_wd    = host_wdata[15:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{idle_lim: IDLE_DEF, sc_wd: '0};
        else        r_q <= r_d;
    end

    eb_grouper #(.NBUF(NBUF), .DEPTH(DEPTH), .TO_W(16)) i_grp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (pkt_valid),
        .in_pkt     (in_pkt),
        .rel_valid  (reg_wr && ra == A_REL),
        .rel_idx    (host_wdata[BI_W-1:0]),
        .idle_limit (r_q.idle_lim),
        .rd_buf     (host_addr[2+SLOT_W +: BI_W]),
        .rd_slot    (host_addr[2 +: SLOT_W]),
        .rd_pkt     (rd_pkt),
        .buf_ready  (buf_ready),
        .buf_open   (buf_open),
        .buf_ts     (buf_ts),
        .buf_cnt    (buf_cnt),
        .late_cnt   (late_cnt),
        .ovf_cnt    (ovf_cnt)
    );

    eb_src_counters #(.NSRC(NSRC), .CW(SRC_CW)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (pkt_valid),
        .hit_idx   (pkt_src[SI_W-1:0]),
        .counts    (src_counts)
    );

    eb_slowctl #(.TGT_W(8), .IDX_W(8), .DW(16), .TIMEOUT(SC_TIMEOUT)) i_sc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (reg_wr && ra == A_CMD),
        .cmd_we    (host_wdata[31]),
        .cmd_tgt   (host_wdata[23:16]),
        .cmd_idx   (host_wdata[15:8]),
        .cmd_wdata (r_q.sc_wd),
        .sc_req    (sc_req),
        .sc_we     (sc_we),
        .sc_tgt    (sc_tgt),
        .sc_idx    (sc_idx),
        .sc_wdata  (sc_wdata),
        .sc_ack    (sc_ack),
        .sc_rdata  (sc_rdata),
        .rsp_busy  (rsp_busy),
        .rsp_err   (rsp_err),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr[9]) begin
            case (host_addr[1:0])
                2'd0:    host_rdata = rd_pkt.hits[31:0];
                2'd1:    host_rdata = rd_pkt.hits[63:32];
                2'd2:    host_rdata = 32'(rd_pkt.ts);
                default: host_rdata = 32'(rd_pkt.src);
            endcase
        end else begin
            for (int b = 0; b < NBUF; b++) begin
                if (ra == 6'(b))
                    host_rdata = {buf_ready[b], buf_open[b], 6'(buf_cnt[b]), buf_ts[b]};
            end
            for (int s = 0; s < NSRC; s++) begin
                if (ra == 6'(A_SRC + s)) host_rdata = 32'(src_counts[s]);
            end
            case (ra)
                A_IDLE:  host_rdata = 32'(r_q.idle_lim);
                A_LATE:  host_rdata = 32'(late_cnt);
                A_OVF:   host_rdata = 32'(ovf_cnt);
                A_WD:    host_rdata = 32'(r_q.sc_wd);
                A_RSP:   host_rdata = {rsp_busy, rsp_err, rsp_done, 13'd0, rsp_data};
                default: ;
            endcase
        end
    end

    logic unused_top;
    assign unused_top = &{1'b0, host_addr[8:6], host_wdata[30:24]};

    // R7
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && ra == A_REL && buf_ready[host_wdata[BI_W-1:0]]
        |=> !buf_ready[$past(host_wdata[BI_W-1:0])]);
endmodule

// File: tb/test_evt_builder.sv
module test_evt_builder;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [23:0] pkt_ts = '0;
    logic [15:0] pkt_src = '0;
    logic [63:0] pkt_hits = '0;
    logic [9:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sc_req, sc_we;
    logic [7:0]  sc_tgt, sc_idx;
    logic [15:0] sc_wdata;
    logic        sc_ack = 1'b0;
    logic [15:0] sc_rdata = '0;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_src [16];

    evt_builder i_evt_builder (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ts(pkt_ts),
        .pkt_src(pkt_src), .pkt_hits(pkt_hits), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sc_req(sc_req), .sc_we(sc_we), .sc_tgt(sc_tgt), .sc_idx(sc_idx),
        .sc_wdata(sc_wdata), .sc_ack(sc_ack), .sc_rdata(sc_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] ts, input logic [15:0] src, input logic [63:0] hits);
        pkt_valid = 1'b1; pkt_ts = ts; pkt_src = src; pkt_hits = hits;
        if (exp_src[src[3:0]] != 8'hFF) exp_src[src[3:0]]++;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [9:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [9:0] paddr(input int b, input int s, input int w);
        return {1'b1, 2'(b), 5'(s), 2'(w)};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin hread(10'(b), d); ck("R11 status", d, 0); end
        hread(10'h0A, d); ck("R11 late", d, 0);
        hread(10'h0B, d); ck("R11 ovf", d, 0);
        hread(10'h0E, d); ck("R11 sc rsp", d, 0);
        hread(10'h09, d); ck("R4 idle default", d, 100);
        ck("R11 sc_req", 32'(sc_req), 0);
        for (int s = 0; s < 16; s++) begin hread(10'(16 + s), d); ck("R11 src", d, 0); end
    endtask

    task automatic t_group;
        logic [31:0] d;
        send(24'd100, 16'h0001, 64'h1111_2222_3333_4444);
        send(24'd100, 16'hA002, 64'hDEAD_BEEF_CAFE_F00D);
        send(24'd100, 16'h0003, 64'h0123_4567_89AB_CDEF);
        hread(10'h00, d); ck("R2 status open", d, 32'h4300_0064);
        hread(paddr(0, 1, 0), d); ck("R1 word0", d, 32'hCAFE_F00D);
        hread(paddr(0, 1, 1), d); ck("R1 word1", d, 32'hDEAD_BEEF);
        hread(paddr(0, 1, 2), d); ck("R1 word2", d, 32'd100);
        hread(paddr(0, 1, 3), d); ck("R1 word3", d, 32'h0000_A002);
        hread(paddr(0, 2, 0), d); ck("R2 slot2", d, 32'h89AB_CDEF);
    endtask

    task automatic t_close;
        logic [31:0] d;
        send(24'd101, 16'h0004, 64'h55);
        hread(10'h00, d); ck("R3 closed", d, 32'h8300_0064);
        hread(10'h01, d); ck("R3 new open", d, 32'h4100_0065);
        hread(paddr(1, 0, 0), d); ck("R3 slot0", d, 32'h55);
    endtask

    task automatic t_late;
        logic [31:0] d;
        send(24'd99, 16'h0005, 64'h66);
        hread(10'h0A, d); ck("R5 late", d, 1);
        hread(10'h01, d); ck("R5 unchanged", d, 32'h4100_0065);
    endtask

    task automatic t_timeout;
        logic [31:0] d;
        send(24'd101, 16'h0006, 64'h77);
        hwrite(10'h09, 32'd5);
        idle(2);
        hread(10'h01, d); ck("R4 still open", d, 32'h4200_0065);
        idle(2);
        hread(10'h01, d); ck("R4 timed out", d, 32'h8200_0065);
        hwrite(10'h09, 32'd0);
        send(24'd200, 16'h0007, 64'h88);
        idle(30);
        hread(10'h02, d); ck("R4 limit 0 keeps open", d, 32'h4100_00C8);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        send(24'd201, 16'h0008, 64'h99);
        send(24'd202, 16'h0009, 64'hAA);
        hread(10'h03, d); ck("R6 buf3 ready", d, 32'h8100_00C9);
        hread(10'h0B, d); ck("R6 ovf no free", d, 1);
        send(24'd203, 16'h000A, 64'hBB);
        hread(10'h0B, d); ck("R6 ovf again", d, 2);
    endtask

    task automatic t_release;
        logic [31:0] d;
        hwrite(10'h08, 32'd0);
        hread(10'h00, d); ck("R7 released", d, 0);
        send(24'd300, 16'h000B, 64'hCC);
        hread(10'h00, d); ck("R7 reused", d, 32'h4100_012C);
        hwrite(10'h08, 32'd0);
        hread(10'h00, d); ck("R7 open not released", d, 32'h4100_012C);
        for (int i = 0; i < 32; i++) send(24'd300, 16'h0005, 64'(i));
        hread(10'h00, d); ck("R6 full buffer", d, 32'h6000_012C);
        hread(10'h0B, d); ck("R6 ovf full", d, 3);
        hread(paddr(0, 31, 0), d); ck("R1 last slot", d, 30);
    endtask

    task automatic t_srccnt;
        logic [31:0] d;
        for (int s = 0; s < 16; s++) begin
            hread(10'(16 + s), d); ck("R8 src count", d, 32'(exp_src[s]));
        end
        for (int i = 0; i < 300; i++) send(24'd300, 16'h0027, 64'h0);
        hread(10'(16 + 7), d); ck("R8 saturate", d, 255);
    endtask

    task automatic t_sc;
        logic [31:0] d;
        hwrite(10'h0D, 32'hBEEF);
        hwrite(10'h0C, 32'h8012_3400);
        ck("R9 req", 32'(sc_req), 1);
        ck("R9 fields", {15'd0, sc_we, sc_tgt, sc_idx}, {15'd0, 1'b1, 8'h12, 8'h34});
        ck("R9 wdata", 32'(sc_wdata), 32'hBEEF);
        idle(3);
        hread(10'h0E, d); ck("R9 busy held", d, 32'h8000_0000);
        sc_ack = 1'b1; @(negedge clk); sc_ack = 1'b0;
        hread(10'h0E, d); ck("R9 write done", d, 32'h2000_0000);
        hwrite(10'h0C, 32'h0012_3500);
        ck("R9 read flag", 32'(sc_we), 0);
        sc_ack = 1'b1; sc_rdata = 16'h5A5A; @(negedge clk); sc_ack = 1'b0;
        hread(10'h0E, d); ck("R9 read data", d, 32'h2000_5A5A);
        hwrite(10'h0C, 32'h0099_0100);
        idle(10);
        hread(10'h0E, d); ck("R10 busy before timeout", d, 32'h8000_0000);
        idle(60);
        hread(10'h0E, d); ck("R10 timeout error", d, 32'h6000_0000);
        ck("R10 req dropped", 32'(sc_req), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) exp_src[s] = '0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_group;
        t_close;
        t_late;
        t_timeout;
        t_overflow;
        t_release;
        t_srccnt;
        t_sc;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule